// File: doc/BRIEF.md
# GPIO Controller with Routable Line Interrupts

This block is a register-mapped general-purpose I/O controller for up to 32 lines, reached over a simple 32-bit peripheral bus with a setup phase and an access phase. Every line has a drive value, a direction bit and a synchronised input sample. Software sets the drive value and the direction through registers and reads the sampled pin values back.

Every line can also raise an interrupt. A per-line enable gates it. Two per-line bits set the sensing: polarity selects high or low, and edge-select picks between level and a one-cycle edge event. A per-line routing byte sends the line's qualified event to one of `NIRQ` shared interrupt wires, or to none. Each wire is the registered OR of every line routed to it.

The bus front end is a three-state phase machine. The states are `BUS_IDLE` (no transfer in progress), `BUS_SETUP` (a setup cycle was seen last cycle) and `BUS_DONE` (an access was completed last cycle). It moves from `BUS_IDLE` or `BUS_DONE` to `BUS_SETUP` when select is high and enable is low. It moves from `BUS_SETUP` to `BUS_DONE` when select and enable are both high, and a write is committed on that transition only. `BUS_SETUP` holds while select stays high with enable low. Every other case returns to `BUS_IDLE`.

Top module: `gpio_irq_router`

## Requirements
- R1: After reset, the drive, direction, enable, polarity and edge-select registers read 0, `pin_oe` and `irq_out` are 0, and every routing word reads 0x80808080 (every line unrouted).
- R2: Writes to the drive (0x04), direction (0x08), enable (0x0C), polarity (0x10) and edge-select (0x14) words read back unchanged, with bit n holding line n.
- R3: `pin_out` equals the drive register and `pin_oe` equals the direction register, where 1 means the line is driven.
- R4: The input word (0x00) and the interrupt logic see each pin through two flops, so a pin change is visible two clock edges after it is sampled.
- R5: When edge-select is 0, polarity 1 asserts the line while its synchronised input is high, and polarity 0 asserts it while the input is low.
- R6: When edge-select is 1, polarity 1 gives a one-cycle event on a rising synchronised input and polarity 0 gives one on a falling input.
- R7: A line whose enable bit is 0 contributes nothing to any interrupt wire.
- R8: The routing byte of line n sits in the word at 0x20 + 4*(n/4), in bits 8*(n%4)+7 down to 8*(n%4). Bit 7 set leaves the line unrouted. Otherwise bits 6:0 give the wire index, and an index of NIRQ or more drives no wire.
- R9: Several lines routed to the same wire are OR-ed onto it.
- R10: Reads of the spare words 0x18 and 0x1C, of words past the routing table, and of addresses with nonzero bits 1:0 return 0. Writes to those addresses and to the input word change nothing.
- R11: `irq_out` is registered. A pin change reaches it on the third rising clock edge after the pin is driven.
- R12: An access-phase cycle with no setup cycle before it commits no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, decoded from paddr |
| pin_in | input | NL | Raw pin inputs |
| pin_out | output | NL | Drive values |
| pin_oe | output | NL | Drive enables |
| irq_out | output | NIRQ | Shared interrupt wires |

## Verification
The hardest case to reach from the ports is an edge event whose pulse has to be told apart from the level it leaves behind. The routing, polarity, edge-select and enable bits must all be set before the pin moves, and the one-cycle pulse then appears three edges later. The stimulus therefore programs a single line fully, parks its pin, and only then toggles it. It samples `irq_out` on the exact edge of the pulse and on the edge after. A behavioural model keeps a queue of pin history and a table of routing entries. It follows random writes, reads and pin changes, and it compares the outputs on every clock.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    typedef enum logic [1:0] {
        BUS_IDLE  = 2'd0,
        BUS_SETUP = 2'd1,
        BUS_DONE  = 2'd2
    } bus_state_e;

    // Word indices (byte address / 4)
    localparam int W_INPUT = 0;
    localparam int W_DRIVE = 1;
    localparam int W_DIR   = 2;
    localparam int W_EN    = 3;
    localparam int W_POL   = 4;
    localparam int W_EDGE  = 5;
    localparam int W_ROUTE = 8;

    localparam int ROUTE_W     = 8;
    localparam int ROUTE_OFF   = 7;
    localparam logic [ROUTE_W-1:0] ROUTE_RESET = 8'h80;

endpackage

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int NL     = 32,
    parameter int ADDR_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      psel,
    input  logic                      penable,
    input  logic                      pwrite,
    input  logic [ADDR_W-1:0]         paddr,
    input  logic [31:0]               pwdata,
    output logic [31:0]               prdata,
    input  logic [NL-1:0]             in_sync,
    output logic [NL-1:0]             drive_q,
    output logic [NL-1:0]             dir_q,
    output logic [NL-1:0]             en_q,
    output logic [NL-1:0]             pol_q,
    output logic [NL-1:0]             edge_q,
    output logic [NL-1:0][ROUTE_W-1:0] route_q,
    output logic                      wr_en
);

    localparam int WORD_W = ADDR_W - 2;
    localparam int NMAPW  = (NL + 3) / 4;

    bus_state_e        state_q, state_d;
    logic [WORD_W-1:0] word;
    logic              aligned;
    int                widx;

    assign word    = paddr[ADDR_W-1:2];
    assign aligned = (paddr[1:0] == 2'b00);
    assign widx    = int'(word);

    function automatic logic [31:0] widen(input logic [NL-1:0] v);
        logic [31:0] r;
        r = '0;
        r[NL-1:0] = v;
        return r;
    endfunction

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BUS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = BUS_IDLE;
        unique case (state_q)
            BUS_IDLE, BUS_DONE: begin
                if (psel && !penable) state_d = BUS_SETUP;
                else                  state_d = BUS_IDLE;
            end
            BUS_SETUP: begin
                if (psel && penable)  state_d = BUS_DONE;
                else if (psel)        state_d = BUS_SETUP;
                else                  state_d = BUS_IDLE;
            end
            default: state_d = BUS_IDLE;
        endcase
    end

    // Output process: write strobe only on the setup-to-done transition
    always_comb begin
        wr_en = 1'b0;
        unique case (state_q)
            BUS_SETUP: wr_en = psel && penable && pwrite && aligned;
            BUS_IDLE, BUS_DONE: wr_en = 1'b0;
            default: wr_en = 1'b0;
        endcase
    end

    // Per-line control registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drive_q <= '0;
            dir_q   <= '0;
            en_q    <= '0;
            pol_q   <= '0;
            edge_q  <= '0;
        end else if (wr_en) begin
            case (widx)
                W_DRIVE: drive_q <= pwdata[NL-1:0];
                W_DIR:   dir_q   <= pwdata[NL-1:0];
                W_EN:    en_q    <= pwdata[NL-1:0];
                W_POL:   pol_q   <= pwdata[NL-1:0];
                W_EDGE:  edge_q  <= pwdata[NL-1:0];
                default: ;
            endcase
        end
    end

    // Routing bytes, four lines per word
    generate
        for (genvar i = 0; i < NL; i++) begin : g_route
            localparam int RW = W_ROUTE + i / 4;
            localparam int RB = 8 * (i % 4);
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    route_q[i] <= ROUTE_RESET;
                end else if (wr_en && widx == RW) begin
                    route_q[i] <= pwdata[RB +: ROUTE_W];
                end
            end
        end
    endgenerate

    // Read decode
    always_comb begin
        prdata = '0;
        if (aligned) begin
            case (widx)
                W_INPUT: prdata = widen(in_sync);
                W_DRIVE: prdata = widen(drive_q);
                W_DIR:   prdata = widen(dir_q);
                W_EN:    prdata = widen(en_q);
                W_POL:   prdata = widen(pol_q);
                W_EDGE:  prdata = widen(edge_q);
                default: begin
                    if (widx >= W_ROUTE && widx < W_ROUTE + NMAPW) begin
                        for (int i = 0; i < NL; i++) begin
                            if (widx == W_ROUTE + i / 4) begin
                                prdata[8*(i%4) +: ROUTE_W] = route_q[i];
                            end
                        end
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/gpio_line_detect.sv
module gpio_line_detect #(
    parameter int NL = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NL-1:0] pin_in,
    input  logic [NL-1:0] en_q,
    input  logic [NL-1:0] pol_q,
    input  logic [NL-1:0] edge_q,
    output logic [NL-1:0] in_sync,
    output logic [NL-1:0] event_o
);

    generate
        for (genvar i = 0; i < NL; i++) begin : g_line
            logic meta_q, sync_q, prev_q;
            logic rise, fall, level_hit, edge_hit;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    meta_q <= 1'b0;
                    sync_q <= 1'b0;
                    prev_q <= 1'b0;
                end else begin
                    meta_q <= pin_in[i];
                    sync_q <= meta_q;
                    prev_q <= sync_q;
                end
            end

            assign rise      = sync_q & ~prev_q;
            assign fall      = ~sync_q & prev_q;
            assign level_hit = pol_q[i] ? sync_q : ~sync_q;
            assign edge_hit  = pol_q[i] ? rise : fall;

            assign in_sync[i] = sync_q;
            assign event_o[i] = en_q[i] & (edge_q[i] ? edge_hit : level_hit);
        end
    endgenerate

endmodule

// File: rtl/gpio_irq_route.sv
module gpio_irq_route
    import gpio_irq_pkg::*;
#(
    parameter int NL   = 32,
    parameter int NIRQ = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NL-1:0]              event_i,
    input  logic [NL-1:0][ROUTE_W-1:0] route_q,
    output logic [NIRQ-1:0]            irq_out
);

    localparam int IDX_W = ROUTE_W - 1;

    logic [NIRQ-1:0] irq_d, irq_q;

    generate
        for (genvar j = 0; j < NIRQ; j++) begin : g_wire
            always_comb begin
                irq_d[j] = 1'b0;
                for (int i = 0; i < NL; i++) begin
                    if (!route_q[i][ROUTE_OFF] &&
                        route_q[i][IDX_W-1:0] == IDX_W'(j) &&
                        event_i[i]) begin
                        irq_d[j] = 1'b1;
                    end
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq_d;
    end

    assign irq_out = irq_q;

endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router
    import gpio_irq_pkg::*;
#(
    parameter int NL     = 32,
    parameter int NIRQ   = 4,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    input  logic [NL-1:0]     pin_in,
    output logic [NL-1:0]     pin_out,
    output logic [NL-1:0]     pin_oe,
    output logic [NIRQ-1:0]   irq_out
);

    logic [NL-1:0]              in_sync;
    logic [NL-1:0]              drive_q, dir_q, en_q, pol_q, edge_q;
    logic [NL-1:0][ROUTE_W-1:0] route_q;
    logic [NL-1:0]              line_event;
    logic                       wr_en;

    gpio_irq_regs #(.NL(NL), .ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .pwdata  (pwdata),
        .prdata  (prdata),
        .in_sync (in_sync),
        .drive_q (drive_q),
        .dir_q   (dir_q),
        .en_q    (en_q),
        .pol_q   (pol_q),
        .edge_q  (edge_q),
        .route_q (route_q),
        .wr_en   (wr_en)
    );

    gpio_line_detect #(.NL(NL)) u_detect (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_in  (pin_in),
        .en_q    (en_q),
        .pol_q   (pol_q),
        .edge_q  (edge_q),
        .in_sync (in_sync),
        .event_o (line_event)
    );

    gpio_irq_route #(.NL(NL), .NIRQ(NIRQ)) u_route (
        .clk     (clk),
        .rst_n   (rst_n),
        .event_i (line_event),
        .route_q (route_q),
        .irq_out (irq_out)
    );

    assign pin_out = drive_q;
    assign pin_oe  = dir_q;

endmodule

// File: rtl/gpio_irq_router_chk.sv
module gpio_irq_router_chk
    import gpio_irq_pkg::*;
#(
    parameter int NL     = 32,
    parameter int NIRQ   = 4,
    parameter int ADDR_W = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       psel,
    input logic                       penable,
    input logic                       pwrite,
    input logic [ADDR_W-1:0]          paddr,
    input logic [31:0]                pwdata,
    input logic [NL-1:0]              pin_in,
    input logic [NL-1:0]              pin_out,
    input logic [NL-1:0]              pin_oe,
    input logic [NIRQ-1:0]            irq_out,
    input logic                       wr_en,
    input logic [NL-1:0]              in_sync,
    input logic [NL-1:0]              en_q,
    input logic [NL-1:0][ROUTE_W-1:0] route_q
);

    localparam int NMAPW = (NL + 3) / 4;

    int   word_i;
    logic unmapped;
    logic none_routed;
    logic [1:0] since;

    assign word_i = int'(paddr[ADDR_W-1:2]);
    assign unmapped = (paddr[1:0] != 2'b00) || word_i == W_INPUT ||
                      (word_i > W_EDGE && word_i < W_ROUTE) ||
                      word_i >= W_ROUTE + NMAPW;

    always_comb begin
        none_routed = 1'b1;
        for (int i = 0; i < NL; i++) begin
            if (!route_q[i][ROUTE_OFF] && int'(route_q[i][ROUTE_W-2:0]) < NIRQ)
                none_routed = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         since <= '0;
        else if (since != 2'd3) since <= since + 2'd1;
    end

    a_r3_oe_after_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && word_i == W_DIR) |=> (pin_oe == $past(pwdata[NL-1:0])));

    a_r4_sync_two_edges: assert property (@(posedge clk) disable iff (!rst_n)
        (since == 2'd3) |-> (in_sync == $past(pin_in, 2)));

    a_r7_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |=> (irq_out == '0));

    a_r8_unrouted_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        none_routed |=> (irq_out == '0));

    a_r10_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable && pwrite && unmapped) |=>
        ($stable(pin_out) && $stable(pin_oe) && $stable(en_q) && $stable(route_q)));

    a_r12_no_setup_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable && pwrite && !$past(psel && !penable)) |=>
        ($stable(pin_out) && $stable(pin_oe) && $stable(en_q)));

endmodule

bind gpio_irq_router gpio_irq_router_chk #(.NL(NL), .NIRQ(NIRQ), .ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .pwdata  (pwdata),
    .pin_in  (pin_in),
    .pin_out (pin_out),
    .pin_oe  (pin_oe),
    .irq_out (irq_out),
    .wr_en   (wr_en),
    .in_sync (in_sync),
    .en_q    (en_q),
    .route_q (route_q)
);

// File: tb/gpio_irq_router_tb_top.sv
module gpio_irq_router_tb_top;

    localparam int NL = 32;
    localparam int NIRQ = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic [NL-1:0] pin_in = '0;
    logic [NL-1:0] pin_out, pin_oe;
    logic [NIRQ-1:0] irq_out;

    int n_checks = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    gpio_irq_router #(.NL(NL), .NIRQ(NIRQ), .ADDR_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
    );

    // ---------------- behavioural reference model ----------------
    bit [31:0] hist[$];
    bit [31:0] m_drive, m_dir, m_en, m_pol, m_edge;
    int        m_rt[NL];
    bit [3:0]  m_irq;
    bit        m_prev_setup;

    task automatic model_reset();
        hist = '{32'h0, 32'h0, 32'h0};
        m_drive = 0; m_dir = 0; m_en = 0; m_pol = 0; m_edge = 0;
        foreach (m_rt[i]) m_rt[i] = 'h80;
        m_irq = 0;
        m_prev_setup = 0;
    endtask

    function automatic bit [31:0] model_read(input bit [7:0] a);
        int w;
        bit [31:0] r;
        w = a >> 2;
        r = 0;
        if (a[1:0] != 0) return 0;
        case (w)
            0: r = hist[1];
            1: r = m_drive;
            2: r = m_dir;
            3: r = m_en;
            4: r = m_pol;
            5: r = m_edge;
            default: if (w >= 8 && w < 16)
                for (int b = 0; b < 4; b++) r[8*b +: 8] = 8'(m_rt[(w-8)*4+b]);
        endcase
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            bit [3:0] nirq;
            bit s, p, ev;
            int w;
            nirq = 0;
            for (int i = 0; i < NL; i++) begin
                s = hist[1][i];
                p = hist[2][i];
                if (m_edge[i]) ev = m_pol[i] ? (s && !p) : (!s && p);
                else           ev = m_pol[i] ? s : !s;
                ev = ev && m_en[i];
                if (ev && m_rt[i] < 128 && m_rt[i] < NIRQ) nirq[m_rt[i]] = 1;
            end
            m_irq = nirq;
            hist.push_front(pin_in);
            void'(hist.pop_back());
            if (m_prev_setup && psel && penable && pwrite && paddr[1:0] == 0) begin
                w = paddr >> 2;
                case (w)
                    1: m_drive = pwdata;
                    2: m_dir = pwdata;
                    3: m_en = pwdata;
                    4: m_pol = pwdata;
                    5: m_edge = pwdata;
                    default: if (w >= 8 && w < 16)
                        for (int b = 0; b < 4; b++) m_rt[(w-8)*4+b] = pwdata[8*b +: 8];
                endcase
            end
            m_prev_setup = psel && !penable;
        end
    end

    // ---------------- checking ----------------
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R11 irq_out vs model", 32'(irq_out), 32'(m_irq));
            chk("R3 pin_out vs model", pin_out, m_drive);
            chk("R3 pin_oe vs model", pin_oe, m_dir);
        end
    end

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
        @(negedge clk); penable = 1;
        @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
        @(negedge clk); penable = 1;
        #1 v = prdata;
        @(negedge clk); psel = 0; penable = 0;
    endtask

    task automatic rd_const(input logic [7:0] a, input logic [31:0] exp, input string tag);
        logic [31:0] v;
        bus_rd(a, v);
        chk(tag, v, exp);
    endtask

    task automatic rd_model(input logic [7:0] a, input string tag);
        logic [31:0] v, e;
        @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
        @(negedge clk); penable = 1;
        #1 v = prdata; e = model_read(a);
        chk(tag, v, e);
        @(negedge clk); psel = 0; penable = 0;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        wait_n(2);

        // R1: reset values
        chk("R1 pin_oe reset", pin_oe, 0);
        chk("R1 irq_out reset", 32'(irq_out), 0);
        rd_const(8'h04, 0, "R1 drive reset");
        rd_const(8'h08, 0, "R1 dir reset");
        rd_const(8'h0C, 0, "R1 enable reset");
        rd_const(8'h10, 0, "R1 polarity reset");
        rd_const(8'h14, 0, "R1 edge reset");
        for (int w = 0; w < 8; w++) rd_const(8'(8'h20 + 4*w), 32'h80808080, "R1 route reset");

        // R2 / R3: readback and pin drive
        bus_wr(8'h04, 32'hDEAD_BEEF);
        bus_wr(8'h08, 32'h0F0F_F0F0);
        rd_const(8'h04, 32'hDEAD_BEEF, "R2 drive readback");
        rd_const(8'h08, 32'h0F0F_F0F0, "R2 dir readback");
        chk("R3 pin_out", pin_out, 32'hDEAD_BEEF);
        chk("R3 pin_oe", pin_oe, 32'h0F0F_F0F0);
        bus_wr(8'h10, 32'h1234_5678);
        bus_wr(8'h14, 32'h8765_4321);
        rd_const(8'h10, 32'h1234_5678, "R2 polarity readback");
        rd_const(8'h14, 32'h8765_4321, "R2 edge readback");
        bus_wr(8'h10, 0);
        bus_wr(8'h14, 0);

        // R4: synchronised input
        pin_in = 32'hA5A5_0F0F;
        wait_n(3);
        rd_const(8'h00, 32'hA5A5_0F0F, "R4 input word");
        pin_in = 0;
        wait_n(3);

        // R10: unmapped and read-only addresses
        bus_wr(8'h18, 32'hFFFF_FFFF);
        bus_wr(8'h1C, 32'hFFFF_FFFF);
        bus_wr(8'h40, 32'hFFFF_FFFF);
        bus_wr(8'h05, 32'h0000_0001);
        bus_wr(8'h00, 32'hFFFF_FFFF);
        rd_const(8'h18, 0, "R10 spare 0x18");
        rd_const(8'h1C, 0, "R10 spare 0x1C");
        rd_const(8'h40, 0, "R10 past routing table");
        rd_const(8'h05, 0, "R10 misaligned read");
        rd_const(8'h04, 32'hDEAD_BEEF, "R10 drive untouched");
        rd_const(8'h00, 0, "R10 input word not writable");

        // R12: access phase with no setup
        @(negedge clk); psel = 1; penable = 1; pwrite = 1; paddr = 8'h04; pwdata = 32'h1111_1111;
        @(negedge clk); psel = 0; penable = 0; pwrite = 0;
        rd_const(8'h04, 32'hDEAD_BEEF, "R12 no write without setup");

        // R5 level-low: line 0 to wire 0, enabled, pol 0, edge 0, pin low
        bus_wr(8'h20, 32'h8080_8000);
        bus_wr(8'h0C, 32'h0000_0001);
        wait_n(2);
        chk("R5 level-low asserts", 32'(irq_out), 32'h1);
        bus_wr(8'h0C, 0);
        wait_n(2);
        chk("R7 disabled line quiet", 32'(irq_out), 0);

        // R11 latency + R5 level-high: line 3 to wire 2
        bus_wr(8'h20, 32'h0280_8080);
        bus_wr(8'h10, 32'h0000_0008);
        bus_wr(8'h0C, 32'h0000_0008);
        wait_n(3);
        chk("R11 idle before pin", 32'(irq_out), 0);
        pin_in[3] = 1;
        wait_n(1); chk("R11 edge1 no irq", 32'(irq_out), 0);
        wait_n(1); chk("R11 edge2 no irq", 32'(irq_out), 0);
        wait_n(1); chk("R11 edge3 irq", 32'(irq_out), 32'h4);
        chk("R5 level-high held", 32'(irq_out), 32'h4);

        // R6 rising edge
        bus_wr(8'h14, 32'h0000_0008);
        pin_in[3] = 0;
        wait_n(5);
        pin_in[3] = 1;
        wait_n(3); chk("R6 rising pulse", 32'(irq_out), 32'h4);
        wait_n(1); chk("R6 rising pulse one cycle", 32'(irq_out), 0);
        // R6 falling edge
        bus_wr(8'h10, 0);
        wait_n(3);
        pin_in[3] = 0;
        wait_n(3); chk("R6 falling pulse", 32'(irq_out), 32'h4);
        wait_n(1); chk("R6 falling pulse one cycle", 32'(irq_out), 0);
        // R7 enable off blocks edge
        bus_wr(8'h0C, 0);
        pin_in[3] = 1;
        wait_n(2);
        pin_in[3] = 0;
        wait_n(4); chk("R7 masked edge", 32'(irq_out), 0);

        // R8 routing variants, line 3 level-high, pin high
        bus_wr(8'h14, 0);
        bus_wr(8'h10, 32'h0000_0008);
        bus_wr(8'h0C, 32'h0000_0008);
        pin_in[3] = 1;
        bus_wr(8'h20, 32'h8580_8080);
        wait_n(3); chk("R8 unrouted bit", 32'(irq_out), 0);
        bus_wr(8'h20, 32'h0780_8080);
        wait_n(3); chk("R8 index beyond wires", 32'(irq_out), 0);
        bus_wr(8'h20, 32'h0180_8080);
        wait_n(3); chk("R8 route to wire 1", 32'(irq_out), 32'h2);
        rd_const(8'h20, 32'h0180_8080, "R8 route readback");

        // R9 sharing: lines 0 and 1 onto wire 0, level-high
        pin_in = 0;
        bus_wr(8'h20, 32'h8080_0000);
        bus_wr(8'h10, 32'h0000_0003);
        bus_wr(8'h0C, 32'h0000_0003);
        wait_n(3); chk("R9 both low", 32'(irq_out), 0);
        pin_in = 32'h2;
        wait_n(3); chk("R9 one of shared lines", 32'(irq_out), 32'h1);
        pin_in = 32'h1;
        wait_n(3); chk("R9 other shared line", 32'(irq_out), 32'h1);

        // Random traffic against the model (R2, R4, R8, R10 mixed)
        for (int k = 0; k < 1500; k++) begin
            int op;
            op = $urandom_range(0, 9);
            if (op < 3) begin
                pin_in = $urandom;
                wait_n($urandom_range(1, 4));
            end else if (op < 6) begin
                bus_wr(8'(4 * $urandom_range(1, 5)), $urandom);
            end else if (op < 8) begin
                bus_wr(8'(8'h20 + 4 * $urandom_range(0, 7)), $urandom & 32'h8787_8787);
            end else begin
                rd_model(8'($urandom_range(0, 80)), "R2 R10 random read vs model");
            end
        end
        wait_n(4);
        report();
    end

endmodule